// File: doc/BRIEF.md
# Access-Checked Register Window Decoder

This block stands between a memory-mapped bus slave port and a small set of register windows. A request carries an absolute bus address, a size code, a read/write flag and write data. The block subtracts a programmable device base from the address to get a 12-bit device offset. It then finds the first window in a fixed, sorted table whose span `[base, base + length)` holds that offset. The size and alignment are checked against the access widths that window allows.

A legal access is forwarded to its window in the same cycle. The block drives a one-hot window select, a read or write strobe, the offset relative to the window start, and the write data converted to numeric value order. The block registers a response one cycle later. A legal read returns the window's value packed into bus byte lanes. Any other access produces a response with an error flag and zero data. An illegal write never reaches a window.

Bus-side data is a byte array. The byte at access address + i sits in bits `[63-8i : 56-8i]`, so the first byte is in the top lane. Region-side data is numeric little-endian: value byte i, bits `[8i+7 : 8i]`, is the byte at access address + i. Bytes beyond the access size are zero.

Top module: `regwin_decoder`

## Requirements
- R1: The device offset selects window k when it is at or above that window's base and strictly below base + length. When several windows match, the lowest index wins. An offset in no window is unmapped.
- R2: The device offset is the bus address minus `devBase`. An address below `devBase`, or 4096 or more above it, is unmapped.
- R3: A one-byte access (reqSize = 0) is legal only if flag bit 0 of the window is set.
- R4: A four-byte access (reqSize = 2) is legal only if flag bit 1 of the window is set and device offset bits [1:0] are zero.
- R5: An eight-byte access (reqSize = 3) is legal only if flag bit 2 of the window is set and device offset bits [2:0] are zero.
- R6: A two-byte access (reqSize = 1) is always illegal.
- R7: On a legal write, `winWrite` is high and `winWdata` byte i equals bus byte `reqWdata[63-8i -: 8]` for i below the access size in bytes. All higher bytes of `winWdata` are zero.
- R8: The response to a legal read carries the selected window's value byte i in `rspRdata[63-8i -: 8]` for i below the access size, with all other bits zero. The response to any write has zero data.
- R9: An unmapped or illegal access raises no strobe and no window select. Its response has `rspErr` = 1 and `rspRdata` = 0.
- R10: `rspValid` is high exactly one cycle after each cycle with `reqValid` high. `rspErr` is high with it for any access that is unmapped or illegal.
- R11: After reset, `rspValid`, `rspErr` and `rspRdata` are zero.
- R12: During a legal access, `winSel` is one-hot on the chosen window, `winOffset` is the device offset minus that window's base, and `winSize` equals `reqSize`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| devBase | input | ADDR_W | Programmable device base address |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Absolute bus address |
| reqSize | input | 2 | Size code: 0 = 1 B, 1 = 2 B, 2 = 4 B, 3 = 8 B |
| reqWdata | input | 64 | Write data, first byte in the top lane |
| winSel | output | NUM_WIN | One-hot window select of a legal access |
| winRead | output | 1 | Read strobe to the selected window |
| winWrite | output | 1 | Write strobe to the selected window |
| winOffset | output | OFF_W | Offset inside the selected window |
| winSize | output | 2 | Size code passed to the window |
| winWdata | output | 64 | Write data in numeric value order |
| winRdata | input | NUM_WIN*64 | Read values from all windows, window k at bits [64k+63:64k] |
| rspValid | output | 1 | Response valid |
| rspErr | output | 1 | Response flags an unmapped or illegal access |
| rspRdata | output | 64 | Read data, first byte in the top lane |

## Verification
Each window is hit with every size code, at aligned and misaligned offsets. This separates the per-window flag check from the alignment check, and shows that the two-byte code is always refused. Offsets are placed on the first and last byte of a window and one past its end, and addresses just below the device base and just beyond the 4 KiB span. These probe the range compare and the base subtraction. Writes with distinct byte values at each size show that the lane-to-value reversal moves every byte to the right place. Moving the device base and repeating an access shows that decode follows `devBase` and not the absolute address.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  localparam int BUS_BYTES = 8;
  localparam int BUS_W     = 8 * BUS_BYTES;
  localparam int FLAG_W    = 3;

  // positions of the access-width permission bits in a window's flags
  localparam int FLAG_B1 = 0;
  localparam int FLAG_B4 = 1;
  localparam int FLAG_B8 = 2;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } accSize_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic       doRead;
    logic       doWrite;
    logic       fault;
    logic [1:0] size;
  } ctrlStrobe_t;

endpackage

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 12,
  parameter int NUM_WIN = 4,
  parameter logic [NUM_WIN*OFF_W-1:0]  WIN_BASE  = '0,
  parameter logic [NUM_WIN*OFF_W-1:0]  WIN_LEN   = '0,
  parameter logic [NUM_WIN*FLAG_W-1:0] WIN_FLAGS = '0
) (
  input  logic [ADDR_W-1:0]  devBase,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [1:0]         reqSize,
  output ctrlStrobe_t        strb,
  output logic [NUM_WIN-1:0] winSel,
  output logic [OFF_W-1:0]   winOffset
);

  localparam int HI_W = ADDR_W + 1 - OFF_W;

  logic [ADDR_W:0]      diff;
  logic                 inSpan;
  logic [OFF_W-1:0]     devOff;
  logic [NUM_WIN-1:0]   hitVec;
  logic [NUM_WIN-1:0]   hitFirst;
  logic [OFF_W-1:0]     selBase;
  logic [FLAG_W-1:0]    selFlags;
  logic                 sizeOk;
  logic                 legal;

  // borrow bit lands in diff[ADDR_W], so an address below the base is out of span
  assign diff   = {1'b0, reqAddr} - {1'b0, devBase};
  assign inSpan = (diff[ADDR_W:OFF_W] == HI_W'(0));
  assign devOff = diff[OFF_W-1:0];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
    localparam logic [OFF_W-1:0] BASE_G = WIN_BASE[g*OFF_W +: OFF_W];
    localparam logic [OFF_W-1:0] LEN_G  = WIN_LEN[g*OFF_W +: OFF_W];
    logic [OFF_W:0] endExcl;
    assign endExcl   = {1'b0, BASE_G} + {1'b0, LEN_G};
    assign hitVec[g] = inSpan && (devOff >= BASE_G) && ({1'b0, devOff} < endExcl);
  end

  // lowest-index match wins
  always_comb begin
    logic found;
    found    = 1'b0;
    hitFirst = '0;
    selBase  = '0;
    selFlags = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (hitVec[i] && !found) begin
        found       = 1'b1;
        hitFirst[i] = 1'b1;
        selBase     = WIN_BASE[i*OFF_W +: OFF_W];
        selFlags    = WIN_FLAGS[i*FLAG_W +: FLAG_W];
      end
    end
  end

  always_comb begin
    unique case (accSize_e'(reqSize))
      SZ_B1:   sizeOk = selFlags[FLAG_B1];
      SZ_B4:   sizeOk = selFlags[FLAG_B4] && (devOff[1:0] == 2'b00);
      SZ_B8:   sizeOk = selFlags[FLAG_B8] && (devOff[2:0] == 3'b000);
      default: sizeOk = 1'b0;
    endcase
  end

  assign legal = reqValid && (|hitFirst) && sizeOk;

  always_comb begin
    strb.doRead  = legal && !reqWrite;
    strb.doWrite = legal && reqWrite;
    strb.fault   = reqValid && !legal;
    strb.size    = reqSize;
  end

  assign winSel    = legal ? hitFirst : '0;
  assign winOffset = devOff - selBase;

endmodule

// File: rtl/regwin_datapath.sv
module regwin_datapath
  import regwin_pkg::*;
#(
  parameter int NUM_WIN = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reqValid,
  input  ctrlStrobe_t              strb,
  input  logic [NUM_WIN-1:0]       winSel,
  input  logic [BUS_W-1:0]         reqWdata,
  input  logic [NUM_WIN*BUS_W-1:0] winRdata,
  output logic [BUS_W-1:0]         winWdata,
  output logic                     rspValid,
  output logic                     rspErr,
  output logic [BUS_W-1:0]         rspRdata
);

  // first byte in top lane on the bus <-> numeric little-endian in the window
  function automatic logic [BUS_W-1:0] lanesToValue(input logic [BUS_W-1:0] lanes,
                                                    input logic [1:0] sz);
    logic [BUS_W-1:0] v;
    int nBytes;
    v      = '0;
    nBytes = 1 << sz;
    for (int b = 0; b < BUS_BYTES; b++)
      if (b < nBytes) v[8*b +: 8] = lanes[8*(BUS_BYTES-1-b) +: 8];
    return v;
  endfunction

  function automatic logic [BUS_W-1:0] valueToLanes(input logic [BUS_W-1:0] v,
                                                    input logic [1:0] sz);
    logic [BUS_W-1:0] lanes;
    int nBytes;
    lanes  = '0;
    nBytes = 1 << sz;
    for (int b = 0; b < BUS_BYTES; b++)
      if (b < nBytes) lanes[8*(BUS_BYTES-1-b) +: 8] = v[8*b +: 8];
    return lanes;
  endfunction

  logic [BUS_W-1:0] readMux;

  always_comb begin
    readMux = '0;
    for (int i = 0; i < NUM_WIN; i++)
      if (winSel[i]) readMux = readMux | winRdata[i*BUS_W +: BUS_W];
  end

  assign winWdata = strb.doWrite ? lanesToValue(reqWdata, strb.size) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= reqValid;
      rspErr   <= strb.fault;
      rspRdata <= strb.doRead ? valueToLanes(readMux, strb.size) : '0;
    end
  end

endmodule

// File: rtl/regwin_decoder.sv
module regwin_decoder
  import regwin_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 12,
  parameter int NUM_WIN = 4,
  parameter logic [NUM_WIN*OFF_W-1:0]  WIN_BASE  = {12'h400, 12'h200, 12'h100, 12'h000},
  parameter logic [NUM_WIN*OFF_W-1:0]  WIN_LEN   = {12'h400, 12'h100, 12'h080, 12'h010},
  parameter logic [NUM_WIN*FLAG_W-1:0] WIN_FLAGS = {3'b001, 3'b110, 3'b011, 3'b010}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     devBase,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [1:0]            reqSize,
  input  logic [63:0]           reqWdata,
  output logic [NUM_WIN-1:0]    winSel,
  output logic                  winRead,
  output logic                  winWrite,
  output logic [OFF_W-1:0]      winOffset,
  output logic [1:0]            winSize,
  output logic [63:0]           winWdata,
  input  logic [NUM_WIN*64-1:0] winRdata,
  output logic                  rspValid,
  output logic                  rspErr,
  output logic [63:0]           rspRdata
);

  ctrlStrobe_t strb;

  regwin_ctrl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .NUM_WIN(NUM_WIN),
    .WIN_BASE(WIN_BASE), .WIN_LEN(WIN_LEN), .WIN_FLAGS(WIN_FLAGS)
  ) u_ctrl (
    .devBase(devBase), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize),
    .strb(strb), .winSel(winSel), .winOffset(winOffset)
  );

  regwin_datapath #(.NUM_WIN(NUM_WIN)) u_dp (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .strb(strb),
    .winSel(winSel), .reqWdata(reqWdata), .winRdata(winRdata),
    .winWdata(winWdata), .rspValid(rspValid), .rspErr(rspErr),
    .rspRdata(rspRdata)
  );

  assign winRead  = strb.doRead;
  assign winWrite = strb.doWrite;
  assign winSize  = strb.size;

endmodule

// File: rtl/regwin_decoder_chk.sv
module regwin_decoder_chk #(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 12,
  parameter int NUM_WIN = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  devBase,
  input logic               reqValid,
  input logic [ADDR_W-1:0]  reqAddr,
  input logic [NUM_WIN-1:0] winSel,
  input logic               winRead,
  input logic               winWrite,
  input logic [1:0]         winSize,
  input logic               rspValid,
  input logic               rspErr,
  input logic [63:0]        rspRdata
);

  logic [ADDR_W-1:0] relAddr;
  assign relAddr = reqAddr - devBase;

  p_onehot_sel_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(winSel));

  p_sel_with_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (|winSel) == (winRead || winWrite));

  p_single_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(winRead && winWrite));

  p_strobe_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (winRead || winWrite) |-> reqValid);

  p_no_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (winRead || winWrite) |-> (winSize != 2'd1));

  p_align_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((winRead || winWrite) && winSize == 2'd2) |-> (relAddr[1:0] == 2'b00));

  p_align_dword_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((winRead || winWrite) && winSize == 2'd3) |-> (relAddr[2:0] == 3'b000));

  p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspValid);

  p_no_spurious_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !rspValid);

  p_err_on_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !winRead && !winWrite) |=> rspErr);

  p_err_zero_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rspErr |-> (rspRdata == 64'd0 && rspValid));

endmodule

bind regwin_decoder regwin_decoder_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .NUM_WIN(NUM_WIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .devBase(devBase), .reqValid(reqValid),
  .reqAddr(reqAddr), .winSel(winSel), .winRead(winRead), .winWrite(winWrite),
  .winSize(winSize), .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata)
);

// File: tb/sim_regwin_decoder.sv
`timescale 1ns/1ps
module sim_regwin_decoder;

  localparam int NW = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [31:0]    devBase = 32'h4000_0000;
  logic           reqValid = 1'b0;
  logic           reqWrite = 1'b0;
  logic [31:0]    reqAddr = '0;
  logic [1:0]     reqSize = '0;
  logic [63:0]    reqWdata = '0;
  logic [NW-1:0]  winSel;
  logic           winRead, winWrite;
  logic [11:0]    winOffset;
  logic [1:0]     winSize;
  logic [63:0]    winWdata;
  logic [NW*64-1:0] winRdata;
  logic           rspValid, rspErr;
  logic [63:0]    rspRdata;

  int nChecks = 0;
  int nFail   = 0;

  // window table as the bench sees it: base, length, permission bits (b0=1B, b1=4B, b2=8B)
  int mBase [NW] = '{'h000, 'h100, 'h200, 'h400};
  int mLen  [NW] = '{'h010, 'h080, 'h100, 'h400};
  int mFlag [NW] = '{2, 3, 6, 1};

  always #2.5 clk = ~clk;

  regwin_decoder u0 (
    .clk(clk), .rst_n(rst_n), .devBase(devBase), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .winSel(winSel), .winRead(winRead), .winWrite(winWrite), .winOffset(winOffset),
    .winSize(winSize), .winWdata(winWdata), .winRdata(winRdata),
    .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata)
  );

  function automatic logic [63:0] stubVal(input int w, input logic [11:0] off);
    return 64'h0807_0605_0403_0201 + 64'(w) * 64'h1010_1010_1010_1010 + 64'(off);
  endfunction

  // window stubs answer every cycle; the decoder picks one
  for (genvar w = 0; w < NW; w++) begin : g_stub
    assign winRdata[w*64 +: 64] = stubVal(w, winOffset);
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [31:0] addr, input logic [1:0] sz,
                        input logic [63:0] wd, input string tag);
    longint rel;
    int idx, nb, off;
    bit ok;
    logic [63:0] expVal, expLanes;
    rel = longint'(addr) - longint'(devBase);
    idx = -1;
    off = int'(rel);
    if (rel >= 0 && rel < 4096)
      for (int k = NW - 1; k >= 0; k--)
        if (off >= mBase[k] && off < mBase[k] + mLen[k]) idx = k;
    ok = 0;
    if (idx >= 0) begin
      if (sz == 2'd0) ok = (mFlag[idx] & 1) != 0;
      if (sz == 2'd2) ok = ((mFlag[idx] & 2) != 0) && (off % 4 == 0);
      if (sz == 2'd3) ok = ((mFlag[idx] & 4) != 0) && (off % 8 == 0);
    end
    nb = 1 << sz;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqSize = sz; reqWdata = wd;
    #1;
    chk(64'(winRead), 64'(ok && !wr), {tag, " read strobe"});
    chk(64'(winWrite), 64'(ok && wr), {tag, " write strobe"});
    chk(64'(winSel), ok ? (64'd1 << idx) : 64'd0, {tag, " R12 select"});
    expLanes = '0;
    if (ok) begin
      chk(64'(winOffset), 64'(off - mBase[idx]), {tag, " R12 offset"});
      chk(64'(winSize), 64'(sz), {tag, " R12 size"});
      if (wr) begin
        expVal = '0;
        for (int b = 0; b < nb; b++) expVal[8*b +: 8] = wd[63 - 8*b -: 8];
        chk(winWdata, expVal, {tag, " R7 write data"});
      end else begin
        expVal = stubVal(idx, 12'(off - mBase[idx]));
        for (int b = 0; b < nb; b++) expLanes[63 - 8*b -: 8] = expVal[8*b +: 8];
      end
    end
    @(negedge clk);
    reqValid = 1'b0;
    chk(64'(rspValid), 64'd1, {tag, " R10 valid"});
    chk(64'(rspErr), 64'(!ok), {tag, " R10 err"});
    chk(rspRdata, expLanes, {tag, " R8 data"});
    @(negedge clk);
    chk(64'(rspValid), 64'd0, {tag, " R10 idle"});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(64'(rspValid), 64'd0, "R11 reset valid");
    chk(64'(rspErr), 64'd0, "R11 reset err");
    chk(rspRdata, 64'd0, "R11 reset data");

    access(0, 32'h4000_0004, 2'd2, '0, "R4 aligned word W0");
    access(0, 32'h4000_0006, 2'd2, '0, "R4 misaligned word");
    access(0, 32'h4000_0004, 2'd0, '0, "R3 byte refused by W0");
    access(1, 32'h4000_0105, 2'd0, 64'hAB00_0000_0000_0000, "R3 byte write W1");
    access(1, 32'h4000_010C, 2'd2, 64'h1122_3344_5566_7788, "R7 word write W1");
    access(0, 32'h4000_0208, 2'd3, '0, "R5 dword read W2");
    access(0, 32'h4000_020C, 2'd3, '0, "R5 misaligned dword");
    access(0, 32'h4000_0108, 2'd3, '0, "R5 dword refused by W1");
    access(1, 32'h4000_02F8, 2'd3, 64'h0123_4567_89AB_CDEF, "R7 dword write W2");
    access(0, 32'h4000_0100, 2'd1, '0, "R6 half refused");
    access(1, 32'h4000_0100, 2'd1, 64'hFFFF_0000_0000_0000, "R6 half write dropped");
    access(0, 32'h4000_000C, 2'd2, '0, "R1 last word W0");
    access(0, 32'h4000_0010, 2'd2, '0, "R1 past end W0");
    access(0, 32'h4000_017F, 2'd0, '0, "R1 last byte W1");
    access(0, 32'h4000_0180, 2'd0, '0, "R1 past end W1");
    access(0, 32'h4000_07FF, 2'd0, '0, "R1 last byte W3");
    access(0, 32'h4000_0400, 2'd0, '0, "R8 byte read W3");
    access(0, 32'h3FFF_FFFF, 2'd0, '0, "R2 below base");
    access(0, 32'h4000_1000, 2'd0, '0, "R2 beyond span");
    access(1, 32'h4000_000A, 2'd2, 64'hDEAD_BEEF_0000_0000, "R9 misaligned write dropped");
    access(1, 32'h4000_0300, 2'd3, 64'h1, "R9 unmapped write dropped");
    devBase = 32'h1234_5000;
    access(0, 32'h1234_5204, 2'd2, '0, "R2 moved base W2");
    access(0, 32'h4000_0004, 2'd2, '0, "R2 old base unmapped");

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule